// File: doc/BRIEF.md
# Three-Level Switch Compare Threshold Mapper

This block drives the six upper switches of a three-level neutral-point-clamped inverter (two per phase: an outer switch 1 and an inner switch 2). It accepts one modulation set per carrier period. A set holds a sorted four-step vector sequence and three dwell times, `ta`, `tb` and `tc`, in carrier ticks. From each set it derives one compare threshold per switch. Each phase level of each step is expanded into the two switch states of that phase. The off states of each switch are counted across the four steps, and that count picks the switch's threshold from a ladder of segment boundaries built from the dwell times. The segment before the first boundary is half of `ta`, because the short vector's time is shared between its two redundant states.

A free-running up/down triangle carrier runs from 0 to `CAR_TOP` and back. A registered gate output is high while the carrier exceeds the switch's active threshold. Sets arrive on a valid/ready input. One set can wait in a single holding slot. `in_ready` is low while the slot is occupied, and a producer that holds `in_valid` high simply waits; nothing is dropped. The waiting set becomes active only at the carrier valley, which the plain output `upd_req` marks so the producer can pace itself. A set offered while `in_ready` is low is not taken and has no effect.

Top module: `tml_switch_mapper`

## Requirements
- R1: Phase level codes map to switch states as follows: level 0 puts both switches off, level 1 turns on switch 2 only, and level 2 turns both on. Code 3 is treated as level 2.
- R2: The off states of a switch are counted over the four steps. A count of 0 selects threshold 0, 1 selects ta/2 (rounded down), 2 selects ta/2+tb, 3 selects ta/2+tb+tc and 4 selects `CAR_TOP`. Any sum above `CAR_TOP` is clamped to `CAR_TOP`.
- R3: The carrier starts at 0 counting up, moves by exactly one per cycle, turns at `CAR_TOP` and at 0, and repeats every 2*`CAR_TOP` cycles.
- R4: `upd_req` is high in exactly those cycles in which the carrier is at 0.
- R5: Each gate is a register. In the cycle after a carrier value c, it is 1 exactly when c is strictly greater than that switch's active threshold. Over one full carrier period, a switch with threshold t < `CAR_TOP` is therefore high for 2*(`CAR_TOP`-t)-1 cycles, and a switch with threshold `CAR_TOP` stays low.
- R6: A set is taken on a clock edge with `in_valid` and `in_ready` both high. It becomes active at the first later edge at which the carrier is 0. Active thresholds change at no other edge.
- R7: `in_ready` is low from the edge that takes a set until the valley edge that activates it. A set presented while `in_ready` is low is not taken and has no effect.
- R8: A synchronous reset sets all gates low, the carrier to 0 counting up, the holding slot to empty and every active threshold to `CAR_TOP`. All gates therefore stay low until the first set is activated.
- R9: In `in_levels`, step k and phase p (A=0, B=1, C=2) occupy bits [(3k+p)*2 +: 2], with step 0 lowest. `gate` bits 0 to 5 are A1, A2, B1, B2, C1, C2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A modulation set is offered |
| in_ready | output | 1 | The holding slot is free |
| in_levels | input | 24 | Four steps of three 2-bit phase levels |
| in_ta | input | CNT_W | Dwell time of the short vector, in ticks |
| in_tb | input | CNT_W | Dwell time of the second vector |
| in_tc | input | CNT_W | Dwell time of the third vector |
| upd_req | output | 1 | High while the carrier is at its valley |
| gate | output | 6 | Upper switch gate drives A1, A2, B1, B2, C1, C2 |

## Verification
The bench builds the block with `CNT_W` = 16 and `CAR_TOP` = 20. A carrier period then takes 40 cycles, so many valleys, several handovers and a mid-run reset fit in a short run. Dwell times of the same order as `CAR_TOP` reach every zero count from 0 to 4 as well as the clamp at `CAR_TOP`. With this short period, a set can be taken right after a valley and a second offer can then be held against a full slot for many cycles.

// File: rtl/tml_pkg.sv
package tml_pkg;
  localparam int NSTEP = 4;
  localparam int NPH   = 3;
  localparam int NSW   = NPH * 2;
  localparam int ZW    = $clog2(NSTEP + 1);
  localparam int LW    = NSTEP * NPH * 2;

  // {switch1, switch2} state for a phase level code
  function automatic logic [1:0] lvl_to_sw(input logic [1:0] lvl);
    logic [1:0] s;
    s[1] = lvl[1];
    s[0] = |lvl;
    return s;
  endfunction
endpackage

// File: rtl/tml_carrier.sv
module tml_carrier #(
  parameter int CNT_W   = 16,
  parameter int CAR_TOP = 1000
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             valley
);
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(CAR_TOP);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      cnt <= cnt + ONE_V;
      if (cnt == TOP_V - ONE_V) up <= 1'b0;
    end else begin
      cnt <= cnt - ONE_V;
      if (cnt == ONE_V) up <= 1'b1;
    end
  end

  assign valley = (cnt == '0);

  a_r3_carrier_in_span: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP_V);
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) + ONE_V) || (cnt == $past(cnt) - ONE_V));
  a_r4_valley_single_cycle: assert property (@(posedge clk) disable iff (rst)
    valley |=> !valley);
endmodule

// File: rtl/tml_zero_count.sv
module tml_zero_count
  import tml_pkg::*;
(
  input  logic [NSTEP*2-1:0] lv,
  output logic [ZW-1:0]      z_sw1,
  output logic [ZW-1:0]      z_sw2
);
  always_comb begin
    z_sw1 = '0;
    z_sw2 = '0;
    for (int k = 0; k < NSTEP; k++) begin
      logic [1:0] s;
      s = lvl_to_sw(lv[k*2 +: 2]);
      if (!s[1]) z_sw1 = z_sw1 + ZW'(1);
      if (!s[0]) z_sw2 = z_sw2 + ZW'(1);
    end
  end
endmodule

// File: rtl/tml_thr_select.sv
module tml_thr_select
  import tml_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CAR_TOP = 1000
) (
  input  logic [ZW-1:0]    zeros,
  input  logic [CNT_W-1:0] ta,
  input  logic [CNT_W-1:0] tb,
  input  logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] thr
);
  localparam int SW = CNT_W + 2;
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(CAR_TOP);
  localparam logic [SW-1:0]    TOP_W = SW'(CAR_TOP);

  logic [SW-1:0] b1, b2, b3;

  assign b1 = SW'(ta >> 1);
  assign b2 = b1 + SW'(tb);
  assign b3 = b2 + SW'(tc);

  function automatic logic [CNT_W-1:0] clamp(input logic [SW-1:0] v);
    return (v > TOP_W) ? TOP_V : v[CNT_W-1:0];
  endfunction

  always_comb begin
    case (zeros)
      ZW'(0):  thr = '0;
      ZW'(1):  thr = clamp(b1);
      ZW'(2):  thr = clamp(b2);
      ZW'(3):  thr = clamp(b3);
      default: thr = TOP_V;
    endcase
  end

  always_comb begin
    a_r2_thr_in_span: assert (thr <= TOP_V);
  end
endmodule

// File: rtl/tml_switch_mapper.sv
module tml_switch_mapper
  import tml_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CAR_TOP = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LW-1:0]    in_levels,
  input  logic [CNT_W-1:0] in_ta,
  input  logic [CNT_W-1:0] in_tb,
  input  logic [CNT_W-1:0] in_tc,
  output logic             upd_req,
  output logic [NSW-1:0]   gate
);
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(CAR_TOP);

  logic [CNT_W-1:0]            cnt;
  logic                        valley;
  logic [NSW-1:0][CNT_W-1:0]   new_thr;
  logic [NSW-1:0][CNT_W-1:0]   pend_thr;
  logic [NSW-1:0][CNT_W-1:0]   act_thr;
  logic                        pend_full;

  tml_carrier #(.CNT_W(CNT_W), .CAR_TOP(CAR_TOP)) u_carrier (
    .clk(clk), .rst(rst), .cnt(cnt), .valley(valley)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [NSTEP*2-1:0] ph_lv;
    logic [ZW-1:0]      z1, z2;
    for (genvar k = 0; k < NSTEP; k++) begin : g_step
      assign ph_lv[k*2 +: 2] = in_levels[(k*NPH+p)*2 +: 2];
    end
    tml_zero_count u_zc (.lv(ph_lv), .z_sw1(z1), .z_sw2(z2));
    tml_thr_select #(.CNT_W(CNT_W), .CAR_TOP(CAR_TOP)) u_sel1 (
      .zeros(z1), .ta(in_ta), .tb(in_tb), .tc(in_tc), .thr(new_thr[2*p])
    );
    tml_thr_select #(.CNT_W(CNT_W), .CAR_TOP(CAR_TOP)) u_sel2 (
      .zeros(z2), .ta(in_ta), .tb(in_tb), .tc(in_tc), .thr(new_thr[2*p+1])
    );
  end

  assign in_ready = !pend_full;
  assign upd_req  = valley;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_full <= 1'b0;
      gate      <= '0;
      for (int i = 0; i < NSW; i++) act_thr[i] <= TOP_V;
    end else begin
      for (int i = 0; i < NSW; i++) gate[i] <= (cnt > act_thr[i]);
      if (valley && pend_full) begin
        act_thr   <= pend_thr;
        pend_full <= 1'b0;
      end else if (in_valid && !pend_full) begin
        pend_thr  <= new_thr;
        pend_full <= 1'b1;
      end
    end
  end

  a_r6_hold_between_valleys: assert property (@(posedge clk) disable iff (rst)
    !(valley && pend_full) |=> $stable(act_thr));
  a_r7_ready_drops_on_take: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  a_r7_ready_held_until_valley: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !valley) |=> !in_ready);
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (gate == '0) && in_ready && upd_req);

  for (genvar i = 0; i < NSW; i++) begin : g_chk
    a_r5_full_thr_blocks: assert property (@(posedge clk) disable iff (rst)
      (act_thr[i] == TOP_V) |=> !gate[i]);
    a_r5_zero_thr_passes: assert property (@(posedge clk) disable iff (rst)
      (act_thr[i] == '0 && cnt != '0) |=> gate[i]);
  end
endmodule

// File: tb/test_tml_switch_mapper.sv
module test_tml_switch_mapper;
  localparam int CNT_W = 16;
  localparam int TOP   = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_levels = '0;
  logic [15:0] in_ta = '0, in_tb = '0, in_tc = '0;
  logic        upd_req;
  logic [5:0]  gate;

  int checks = 0;
  int failures = 0;
  bit chk_en = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tml_switch_mapper #(.CNT_W(CNT_W), .CAR_TOP(TOP)) i_tml_switch_mapper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_levels(in_levels), .in_ta(in_ta), .in_tb(in_tb), .in_tc(in_tc),
    .upd_req(upd_req), .gate(gate)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] stp(input int a, input int b, input int c);
    return {2'(c), 2'(b), 2'(a)};
  endfunction

  // Threshold from R1/R2/R9
  function automatic int thr_of(input logic [23:0] lv, input int ta, input int tb,
                                input int tc, input int sw);
    int ph, z, v;
    ph = sw / 2;
    z = 0;
    for (int k = 0; k < 4; k++) begin
      int lvl;
      bit on;
      lvl = int'(lv[(k*3+ph)*2 +: 2]);
      on = (sw % 2 == 0) ? (lvl >= 2) : (lvl >= 1);
      if (!on) z++;
    end
    case (z)
      0: v = 0;
      1: v = ta / 2;
      2: v = ta / 2 + tb;
      3: v = ta / 2 + tb + tc;
      default: v = TOP;
    endcase
    return (v > TOP) ? TOP : v;
  endfunction

  function automatic int duty(input int thr);
    return (thr >= TOP) ? 0 : 2 * (TOP - thr) - 1;
  endfunction

  // Behavioural reference model
  int m_cnt, m_up, m_full;
  int m_act[6], m_pend[6], m_gate[6];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_full = 0;
      for (int i = 0; i < 6; i++) begin m_act[i] = TOP; m_gate[i] = 0; end
    end else begin
      for (int i = 0; i < 6; i++) m_gate[i] = (m_cnt > m_act[i]) ? 1 : 0;
      if (m_cnt == 0 && m_full == 1) begin
        for (int i = 0; i < 6; i++) m_act[i] = m_pend[i];
        m_full = 0;
      end else if (in_valid && m_full == 0) begin
        for (int i = 0; i < 6; i++)
          m_pend[i] = thr_of(in_levels, int'(in_ta), int'(in_tb), int'(in_tc), i);
        m_full = 1;
      end
      if (m_up == 1) begin
        m_cnt++;
        if (m_cnt == TOP) m_up = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_up = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      for (int i = 0; i < 6; i++) check("R5 R6 R9 gate vs model", int'(gate[i]), m_gate[i]);
      check("R7 ready vs model", int'(in_ready), (m_full == 0) ? 1 : 0);
      check("R4 upd_req vs model", int'(upd_req), (m_cnt == 0) ? 1 : 0);
    end
  end

  task automatic send(input logic [23:0] lv, input int ta, input int tb, input int tc);
    @(negedge clk);
    in_levels = lv; in_ta = 16'(ta); in_tb = 16'(tb); in_tc = 16'(tc);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_active();
    do @(negedge clk); while (!(upd_req && !in_ready));
    do @(negedge clk); while (!upd_req);
  endtask

  task automatic measure(input string tag, input int exp[6]);
    int hi[6];
    for (int i = 0; i < 6; i++) hi[i] = 0;
    repeat (2 * TOP) begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) hi[i] += int'(gate[i]);
    end
    for (int i = 0; i < 6; i++) check(tag, hi[i], exp[i]);
  endtask

  task automatic run_set(input string tag, input logic [23:0] lv,
                         input int ta, input int tb, input int tc);
    int e[6];
    for (int i = 0; i < 6; i++) e[i] = duty(thr_of(lv, ta, tb, tc, i));
    send(lv, ta, tb, tc);
    wait_active();
    measure(tag, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int per;
    logic [23:0] lv;
    logic [23:0] lv_other;

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 gates low in reset", int'(gate), 0);
    check("R8 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    chk_en = 1;
    do @(negedge clk); while (!upd_req);
    measure("R8 all gates off before first set", '{0, 0, 0, 0, 0, 0});

    // R3: carrier period
    do @(negedge clk); while (!upd_req);
    per = 0;
    do begin @(negedge clk); per++; end while (!upd_req);
    check("R3 carrier period", per, 2 * TOP);

    // R1 R2 R9: sorted example sequence, literal duties
    lv = {stp(2,1,1), stp(2,1,0), stp(2,0,0), stp(1,0,0)};
    send(lv, 8, 6, 6);
    wait_active();
    measure("R1 R2 R9 example sequence", '{31, 39, 0, 19, 0, 7});

    // R1: code 3 acts as level 2
    run_set("R1 code 3", {stp(2,2,3), stp(1,2,3), stp(1,1,3), stp(0,1,3)}, 10, 4, 6);

    // R2: clamp of long segment sums
    run_set("R2 clamp", {stp(2,2,1), stp(2,1,1), stp(1,1,0), stp(1,0,0)}, 20, 20, 20);

    // R2: other distribution
    run_set("R2 mixed", {stp(2,2,2), stp(2,1,2), stp(1,1,1), stp(0,0,1)}, 6, 2, 12);

    // R7: offer rejected while slot full
    lv = {stp(1,1,2), stp(1,0,2), stp(0,0,2), stp(0,0,1)};
    lv_other = {stp(2,2,2), stp(2,2,2), stp(2,2,2), stp(2,2,2)};
    do @(negedge clk); while (!upd_req);
    in_levels = lv; in_ta = 16'd4; in_tb = 16'd8; in_tc = 16'd8;
    in_valid = 1'b1;
    @(negedge clk);
    check("R7 ready low after take", int'(in_ready), 0);
    in_levels = lv_other; in_ta = 16'd2; in_tb = 16'd2; in_tc = 16'd2;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    wait_active();
    begin
      int e[6];
      for (int i = 0; i < 6; i++) e[i] = duty(thr_of(lv, 4, 8, 8, i));
      measure("R7 blocked offer has no effect", e);
    end

    // R8: mid-run reset
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 gates low after reset", int'(gate), 0);
    check("R8 ready after reset", int'(in_ready), 1);
    check("R8 carrier at valley after reset", int'(upd_req), 1);
    rst = 1'b0;
    do @(negedge clk); while (!upd_req);
    measure("R8 thresholds restored", '{0, 0, 0, 0, 0, 0});

    // R6: activation after reset
    run_set("R6 activation after reset",
            {stp(2,1,0), stp(2,0,0), stp(1,0,0), stp(1,0,0)}, 12, 4, 4);

    finish_run();
  end
endmodule